// File: doc/BRIEF.md
# Multi-Width CRC32C Accumulator

This block advances a running 32-bit cyclic redundancy check that uses the Castagnoli generator polynomial (0x11EDC6F41). Each request supplies the previous CRC value and a data operand 8, 16, 32 or 64 bits wide. One cycle later the block returns the updated CRC and a one-cycle done strobe. Because each result is the next request's starting value, a caller can walk a buffer of any length by chaining requests and mixing operand widths as the alignment allows.

Bits are consumed in reflected order, least significant bit first, against the bit-reversed polynomial 0x82F63B78. A multi-byte operand is taken lowest byte first. The result is zero-extended into a 64-bit destination. The caller picks the initial value and applies any final complement; the block does neither.

Top module: `crc32c_acc`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `crc_out` is zero and `done` is low.
- R2: With `req_width` = 2'b00, one byte `data_in[7:0]` is folded into `crc_in`, LSB first, against the reflected polynomial 0x82F63B78. `data_in[63:8]` has no effect on the result.
- R3: With `req_width` = 2'b01, `data_in[15:0]` is folded in as two bytes, `data_in[7:0]` first. `data_in[63:16]` has no effect.
- R4: With `req_width` = 2'b10, `data_in[31:0]` is folded in as four bytes, lowest byte first. `data_in[63:32]` has no effect.
- R5: With `req_width` = 2'b11, all eight bytes of `data_in` are folded in, lowest byte first.
- R6: `crc_out[63:32]` is always zero, and the updated CRC sits in `crc_out[31:0]`.
- R7: A request sampled with `req_valid` high at a rising edge yields `done` high and the new `crc_out` after that same edge, a latency of one cycle.
- R8: In a cycle with `req_valid` low, `done` goes low at the next edge, and `crc_out` keeps its value whatever `crc_in`, `data_in` and `req_width` do.
- R9: Chaining requests from 0xFFFFFFFF over the ASCII bytes "123456789" and complementing the final result outside the block gives 0xE3069283, whatever mix of widths covers the string.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one update per high cycle |
| req_width | input | 2 | Operand width: 00 = 8, 01 = 16, 10 = 32, 11 = 64 bits |
| crc_in | input | 32 | Previous CRC value |
| data_in | input | 64 | Data operand, right-aligned |
| crc_out | output | 64 | Updated CRC, zero-extended |
| done | output | 1 | High for one cycle after each request |

## Verification
Every width is driven with nonzero bytes above the selected lane. A design that decodes the width wrongly, or lets stray lanes into the XOR network, returns a wrong CRC for the narrow widths. Each expected value comes from a bit-serial reference that runs over the whole operand at once. That makes it sensitive to byte order and to bit reflection: a design that consumes the high byte first or shifts MSB first fails every multi-byte vector. The published check value is reached through three different width mixes, so an error that shows only when requests are chained is caught. Idle cycles with changing inputs expose a design that loads the output register without a request or keeps `done` high.

// File: rtl/crc32c_pkg.sv
package crc32c_pkg;

  // Bit-reversed form of 0x11EDC6F41 (implicit x^32 dropped)
  localparam logic [31:0] CRC32C_POLY_REFL = 32'h82F63B78;

  typedef enum logic [1:0] {
    WSEL_8  = 2'b00,
    WSEL_16 = 2'b01,
    WSEL_32 = 2'b10,
    WSEL_64 = 2'b11
  } wsel_e;

  // Number of bytes consumed for a width code
  function automatic int unsigned wsel_bytes(input logic [1:0] w);
    return 32'd1 << w;
  endfunction

  // One reflected bit step: shift right, fold polynomial on carry-out
  function automatic logic [31:0] crc_bit_step(input logic [31:0] c,
                                               input logic        d,
                                               input logic [31:0] poly);
    logic fb;
    fb = c[0] ^ d;
    return (c >> 1) ^ (fb ? poly : 32'h0);
  endfunction

endpackage

// File: rtl/crc32c_byte_stage.sv
module crc32c_byte_stage #(
  parameter int          CRC_W = 32,
  parameter logic [31:0] POLY  = crc32c_pkg::CRC32C_POLY_REFL
) (
  input  logic [CRC_W-1:0] c_in,
  input  logic [7:0]       d_in,
  output logic [CRC_W-1:0] c_out
);
  // Eight unrolled bit steps, LSB of the byte first
  always_comb begin
    logic [CRC_W-1:0] acc;
    acc = c_in;
    for (int b = 0; b < 8; b++) begin
      acc = crc32c_pkg::crc_bit_step(acc, d_in[b], POLY);
    end
    c_out = acc;
  end
endmodule

// File: rtl/crc32c_lane_chain.sv
module crc32c_lane_chain #(
  parameter int          CRC_W  = 32,
  parameter int          DATA_W = 64,
  parameter logic [31:0] POLY   = crc32c_pkg::CRC32C_POLY_REFL,
  localparam int         LANES  = DATA_W / 8
) (
  input  logic [CRC_W-1:0]  seed,
  input  logic [DATA_W-1:0] data,
  output logic [CRC_W-1:0]  taps [LANES]
);
  logic [CRC_W-1:0] link [LANES+1];
  assign link[0] = seed;

  // Byte k is folded after bytes 0..k-1; taps[k] holds the CRC after k+1 bytes
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    crc32c_byte_stage #(.CRC_W(CRC_W), .POLY(POLY)) u_stage (
      .c_in  (link[k]),
      .d_in  (data[8*k +: 8]),
      .c_out (link[k+1])
    );
    assign taps[k] = link[k+1];
  end
endmodule

// File: rtl/crc32c_width_pick.sv
module crc32c_width_pick #(
  parameter int  CRC_W = 32,
  parameter int  LANES = 8,
  localparam int SEL_W = 2
) (
  input  logic [CRC_W-1:0] taps [LANES],
  input  logic [SEL_W-1:0] wsel,
  output logic [CRC_W-1:0] picked
);
  // Width code w selects the tap after 2**w bytes
  always_comb begin
    picked = taps[0];
    for (int w = 0; w < (1 << SEL_W); w++) begin
      if (wsel == SEL_W'(w) && (crc32c_pkg::wsel_bytes(SEL_W'(w)) <= LANES)) begin
        picked = taps[crc32c_pkg::wsel_bytes(SEL_W'(w)) - 1];
      end
    end
  end
endmodule

// File: rtl/crc32c_acc.sv
module crc32c_acc #(
  parameter int          CRC_W  = 32,
  parameter int          DATA_W = 64,
  parameter int          DEST_W = 64,
  parameter logic [31:0] POLY   = crc32c_pkg::CRC32C_POLY_REFL
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_width,
  input  logic [CRC_W-1:0]  crc_in,
  input  logic [DATA_W-1:0] data_in,
  output logic [DEST_W-1:0] crc_out,
  output logic              done
);
  localparam int LANES = DATA_W / 8;
  localparam int PAD_W = DEST_W - CRC_W;

  logic [CRC_W-1:0] lane_taps [LANES];
  logic [CRC_W-1:0] next_crc;
  logic             upd_fire;

  crc32c_lane_chain #(.CRC_W(CRC_W), .DATA_W(DATA_W), .POLY(POLY)) u_chain (
    .seed (crc_in),
    .data (data_in),
    .taps (lane_taps)
  );

  crc32c_width_pick #(.CRC_W(CRC_W), .LANES(LANES)) u_pick (
    .taps   (lane_taps),
    .wsel   (req_width),
    .picked (next_crc)
  );

  assign upd_fire = req_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_out <= '0;
      done    <= 1'b0;
    end else begin
      done <= upd_fire;
      if (upd_fire) crc_out <= {{PAD_W{1'b0}}, next_crc};
    end
  end
endmodule

// File: rtl/crc32c_acc_chk.sv
module crc32c_acc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [1:0]  req_width,
  input logic [31:0] crc_in,
  input logic [63:0] data_in,
  input logic [63:0] crc_out,
  input logic        done,
  input logic        upd_fire
);
  logic [63:0] lane_mask;
  always_comb begin
    case (req_width)
      2'b00:   lane_mask = 64'h0000_0000_0000_00FF;
      2'b01:   lane_mask = 64'h0000_0000_0000_FFFF;
      2'b10:   lane_mask = 64'h0000_0000_FFFF_FFFF;
      default: lane_mask = 64'hFFFF_FFFF_FFFF_FFFF;
    endcase
  end

  AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    upd_fire |=> done); // R7
  AST_NO_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !done); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(crc_out)); // R8
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    crc_out[63:32] == 32'h0); // R6
  AST_ZERO_IN_ZERO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && crc_in == 32'h0 && (data_in & lane_mask) == 64'h0) |=> crc_out == 64'h0); // R2
endmodule

bind crc32c_acc crc32c_acc_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_width (req_width),
  .crc_in    (crc_in),
  .data_in   (data_in),
  .crc_out   (crc_out),
  .done      (done),
  .upd_fire  (upd_fire)
);

// File: tb/crc32c_acc_tb.sv
module crc32c_acc_tb;
  localparam time CLK_P = 10ns;
  localparam int  NVEC  = 8;

  localparam logic [1:0]  V_W   [NVEC] = '{2'b00, 2'b00, 2'b01, 2'b01, 2'b10, 2'b10, 2'b11, 2'b11};
  localparam logic [31:0] V_CRC [NVEC] = '{32'h0, 32'hFFFFFFFF, 32'h12345678, 32'hDEADBEEF,
                                          32'h0, 32'hA5A5A5A5, 32'hFFFFFFFF, 32'h0BADF00D};
  localparam logic [63:0] V_DAT [NVEC] = '{64'hFFFF_FFFF_FFFF_FF00, 64'h1122_3344_5566_7780,
                                          64'hAAAA_BBBB_CCCC_0102, 64'h7777_7777_7777_FEDC,
                                          64'hCAFE_BABE_8000_0001, 64'h0101_0101_3141_5926,
                                          64'h0123_4567_89AB_CDEF, 64'h8000_0000_0000_0001};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_width = 2'b00;
  logic [31:0] crc_in = '0;
  logic [63:0] data_in = '0;
  logic [63:0] crc_out;
  logic        done;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  crc32c_acc u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_width(req_width),
    .crc_in(crc_in), .data_in(data_in), .crc_out(crc_out), .done(done)
  );

  // Bit-serial reference over the whole operand, LSB of data_in first
  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [63:0] d,
                                          input logic [1:0] w);
    int nbits = 8 << w;
    for (int i = 0; i < nbits; i++) begin
      logic fb = c[0] ^ d[i];
      c = {1'b0, c[31:1]};
      if (fb) c = c ^ 32'h82F63B78;
    end
    return c;
  endfunction

  task automatic check64(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Drive one request; returns after the capturing edge, at the next falling edge
  task automatic issue(input logic [1:0] w, input logic [31:0] c, input logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_width = w; crc_in = c; data_in = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic chain(input logic [1:0] w, input logic [63:0] d, inout logic [31:0] acc);
    issue(w, acc, d);
    acc = crc_out[31:0];
  endtask

  initial begin
    logic [31:0] acc;
    logic [63:0] held;
    string tags [4] = '{"R2", "R3", "R4", "R5"};
    // R1: reset state
    repeat (3) @(negedge clk);
    check64("R1 crc_out in reset", crc_out, 64'h0);
    check64("R1 done in reset", {63'h0, done}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check64("R1 crc_out after reset", crc_out, 64'h0);
    check64("R1 done after reset", {63'h0, done}, 64'h0);

    // Vector table: R2..R5 by width, R6 upper half, R7 done timing
    for (int v = 0; v < NVEC; v++) begin
      issue(V_W[v], V_CRC[v], V_DAT[v]);
      check64(tags[V_W[v]], crc_out, {32'h0, ref_crc(V_CRC[v], V_DAT[v], V_W[v])});
      check64("R7 done one cycle after request", {63'h0, done}, 64'h1);
      check64("R6 upper half zero", {32'h0, crc_out[63:32]}, 64'h0);
    end

    // R8: idle cycles with moving inputs leave the output alone
    held = crc_out;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      req_width = 2'(k); crc_in = 32'h1111_0000 + k; data_in = {16{4'(k + 3)}};
      check64("R8 crc_out held while idle", crc_out, held);
      check64("R8 done low while idle", {63'h0, done}, 64'h0);
    end

    // R7: back-to-back requests, one result per cycle
    @(negedge clk);
    req_valid = 1'b1; req_width = 2'b10; crc_in = 32'hFFFFFFFF; data_in = 64'h0000_0000_6162_6364;
    @(negedge clk);
    check64("R7 back-to-back first", crc_out, {32'h0, ref_crc(32'hFFFFFFFF, 64'h6162_6364, 2'b10)});
    req_width = 2'b11; crc_in = 32'h0; data_in = 64'hFEDC_BA98_7654_3210;
    @(negedge clk);
    req_valid = 1'b0;
    check64("R7 back-to-back second", crc_out, {32'h0, ref_crc(32'h0, 64'hFEDC_BA98_7654_3210, 2'b11)});
    check64("R7 done stays high", {63'h0, done}, 64'h1);

    // R3/R5: byte order, multi-byte equals successive single-byte steps
    acc = 32'h5A5A5A5A;
    for (int b = 0; b < 8; b++) acc = ref_crc(acc, {56'h0, 8'(8'h10 + 8'(b*17))}, 2'b00);
    issue(2'b11, 32'h5A5A5A5A, 64'h87_76_65_54_43_32_21_10);
    check64("R5 equals eight byte steps", crc_out, {32'h0, acc});

    // R9: "123456789" check value under three width mixes
    acc = 32'hFFFFFFFF;
    for (int b = 0; b < 9; b++) chain(2'b00, {56'h0, 8'(8'h31 + b)}, acc);
    check64("R9 nine byte requests", {32'h0, ~acc}, {32'h0, 32'hE3069283});
    acc = 32'hFFFFFFFF;
    chain(2'b11, 64'h3837363534333231, acc);
    chain(2'b00, 64'hFFFF_FFFF_FFFF_FF39, acc);
    check64("R9 64+8 requests", {32'h0, ~acc}, {32'h0, 32'hE3069283});
    acc = 32'hFFFFFFFF;
    chain(2'b10, 64'h34333231, acc);
    chain(2'b01, 64'h3635, acc);
    chain(2'b01, 64'h3837, acc);
    chain(2'b00, 64'h39, acc);
    check64("R9 32+16+16+8 requests", {32'h0, ~acc}, {32'h0, 32'hE3069283});

    // R1: reset mid-stream clears the output
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check64("R1 reset clears crc_out", crc_out, 64'h0);
    rst_n = 1'b1;

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule